// File: doc/BRIEF.md
# Parallel Port Register Interface

This block sits between a small host register bus and the pins of a PC-style parallel port. A host sees three byte-wide registers. The data register drives the eight data lines. The status register shows the printer-side inputs. The control register drives the four handshake outputs and holds the interrupt-enable bit and the data-direction bit. The pin levels follow the usual mix of inverted and direct polarities. When the direction bit is set, the data output drivers are released so that a peripheral can drive the lines.

Every external input passes through a two-flop synchronizer before use. The interrupt output is a sticky flag. It is set by a rising edge on the synchronized acknowledge line while interrupts are enabled, and a host read of the status register clears it.

Top module: `pport_regfile`

## Requirements
- R1: After reset the data and control registers are zero. So pin_strobe_n, pin_autofd_n and pin_selin_n are 1, pin_init_n is 0, pin_data_oe is 1, pin_data_out is 0 and irq is 0.
- R2: A write to address 0 puts host_wdata on pin_data_out from the next clock edge.
- R3: Control bit 5 is the direction bit. When it is 1, pin_data_oe is 0. When it is 0, pin_data_oe is 1. pin_data_out keeps the data register value in both cases.
- R4: A read of address 0 returns the synchronized level of pin_data_in, not the last value written.
- R5: A read of address 1 returns the status byte. Bit 7 is the inverse of pin_busy. Bit 6 is pin_ack_n, bit 5 is pin_perror, bit 4 is pin_select and bit 3 is pin_fault_n. Bits 2..0 read 0.
- R6: Control bit 0 drives pin_strobe_n inverted. Bit 1 drives pin_autofd_n inverted. Bit 3 drives pin_selin_n inverted. Bit 2 drives pin_init_n directly.
- R7: A read of address 2 returns control bits 5..0. Bits 7..6 read 0 whatever was written to them. A read of address 3 returns 0.
- R8: A write to address 1 changes neither the data register nor the control register.
- R9: While control bit 4 is 1, a rising edge of the synchronized pin_ack_n sets irq. A falling edge does not set it. An edge that occurs while bit 4 is 0 does not set it.
- R10: irq stays set until a host read of address 1. If that read falls in the same cycle as a new qualifying edge, irq stays set.
- R11: A change on any input pin reaches the register reads after two clock edges, and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe (a read of address 1 clears irq) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from host_addr |
| pin_data_in | input | 8 | Levels sampled on the data lines |
| pin_data_out | output | 8 | Value for the data line drivers |
| pin_data_oe | output | 1 | Data driver enable, 1 = drive |
| pin_busy | input | 1 | Busy input |
| pin_ack_n | input | 1 | Acknowledge input, active low |
| pin_perror | input | 1 | Paper-error input |
| pin_select | input | 1 | Select input |
| pin_fault_n | input | 1 | Fault input, active low |
| pin_strobe_n | output | 1 | Strobe output, active low |
| pin_autofd_n | output | 1 | Auto-feed output, active low |
| pin_selin_n | output | 1 | Select-in output, active low |
| pin_init_n | output | 1 | Initialise output, active low |
| irq | output | 1 | Sticky interrupt request |

## Verification
Two events can fall in the same cycle: the status read that clears the interrupt, and a new acknowledge rising edge that sets it. The bench first sets irq with one edge and then lowers the acknowledge line. It raises the line again and times a status read so that the strobe is held over the edge where the synchronized rise is seen. irq must still be 1 after that cycle, and a following plain status read must clear it.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_DATA   = 2'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

    // Control register bit order is fixed by the host software view.
    typedef struct packed {
        logic dir_in;    // bit 5
        logic irq_en;    // bit 4
        logic sel;       // bit 3
        logic init;      // bit 2
        logic autofd;    // bit 1
        logic strobe;    // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic busy;
        logic ack_n;
        logic perror;
        logic select;
        logic fault_n;
    } stat_in_t;

    localparam int STAT_W = $bits(stat_in_t);

    function automatic logic [DATA_W-1:0] status_byte(stat_in_t s);
        return {~s.busy, s.ack_n, s.perror, s.select, s.fault_n, 3'b000};
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_byte(ctrl_t c);
        return {{(DATA_W-CTRL_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[i] <= '0;
                    else     stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/pport_irq.sv
module pport_irq (
    input  logic clk,
    input  logic rst,
    input  logic ack_n_sync,
    input  logic enable,
    input  logic clear,
    output logic irq
);
    logic ack_prev_q;
    logic flag_q;
    logic rise;

    assign rise = ack_n_sync & ~ack_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_prev_q <= 1'b0;
            flag_q     <= 1'b0;
        end else begin
            ack_prev_q <= ack_n_sync;
            if (rise && enable) flag_q <= 1'b1;   // a new edge wins over clear
            else if (clear)     flag_q <= 1'b0;
        end
    end

    assign irq = flag_q;

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
        (ack_n_sync && !ack_prev_q && enable) |=> irq);                    // R9
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clear && !(ack_n_sync && !ack_prev_q && enable)) |=> !irq);       // R10
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !clear) |=> irq);                                          // R10
    AST_IRQ_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!irq && !(ack_n_sync && !ack_prev_q && enable)) |=> !irq);        // R9
endmodule

// File: rtl/pport_regfile.sv
module pport_regfile
    import pport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [DATA_W-1:0] pin_data_in,
    output logic [DATA_W-1:0] pin_data_out,
    output logic              pin_data_oe,
    input  logic              pin_busy,
    input  logic              pin_ack_n,
    input  logic              pin_perror,
    input  logic              pin_select,
    input  logic              pin_fault_n,
    output logic              pin_strobe_n,
    output logic              pin_autofd_n,
    output logic              pin_selin_n,
    output logic              pin_init_n,
    output logic              irq
);
    localparam int IN_W = DATA_W + STAT_W;

    logic [IN_W-1:0]   raw_in, sync_in;
    logic [DATA_W-1:0] data_sync;
    stat_in_t          stat_sync;
    logic [DATA_W-1:0] data_q;
    ctrl_t             ctrl_q;
    logic              stat_rd;

    assign raw_in = {pin_data_in, pin_busy, pin_ack_n, pin_perror, pin_select, pin_fault_n};

    pport_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (raw_in),
        .d_out (sync_in)
    );

    assign data_sync = sync_in[IN_W-1 -: DATA_W];
    assign stat_sync = stat_in_t'(sync_in[STAT_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            ctrl_q <= '0;
        end else if (host_wr) begin
            if (host_addr == A_DATA) data_q <= host_wdata;
            if (host_addr == A_CTRL) ctrl_q <= ctrl_t'(host_wdata[CTRL_W-1:0]);
        end
    end

    assign stat_rd = host_rd && (host_addr == A_STATUS);

    pport_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .ack_n_sync (stat_sync.ack_n),
        .enable     (ctrl_q.irq_en),
        .clear      (stat_rd),
        .irq        (irq)
    );

    always_comb begin
        unique case (host_addr)
            A_DATA:   host_rdata = data_sync;
            A_STATUS: host_rdata = status_byte(stat_sync);
            A_CTRL:   host_rdata = ctrl_byte(ctrl_q);
            default:  host_rdata = '0;
        endcase
    end

    assign pin_data_out = data_q;
    assign pin_data_oe  = ~ctrl_q.dir_in;
    assign pin_strobe_n = ~ctrl_q.strobe;
    assign pin_autofd_n = ~ctrl_q.autofd;
    assign pin_selin_n  = ~ctrl_q.sel;
    assign pin_init_n   =  ctrl_q.init;

    AST_DATA_WRITE: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == A_DATA) |=> pin_data_out == $past(host_wdata));     // R2
    AST_DIR_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == A_CTRL && host_wdata[5]) |=> !pin_data_oe);        // R3
    AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == A_STATUS) |=>
            $stable(pin_data_out) && $stable(pin_data_oe) && $stable(pin_strobe_n)
            && $stable(pin_init_n));                                                 // R8
    AST_STROBE_POLARITY: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == A_CTRL) |=> pin_strobe_n == !$past(host_wdata[0])); // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (host_addr == A_STATUS) |-> host_rdata[2:0] == 3'b000);                      // R5
endmodule

// File: tb/tb_pport_regfile.sv
module tb_pport_regfile;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] host_addr;
    logic       host_wr, host_rd;
    logic [7:0] host_wdata, host_rdata;
    logic [7:0] pin_data_in, pin_data_out;
    logic       pin_data_oe, pin_busy, pin_ack_n, pin_perror, pin_select, pin_fault_n;
    logic       pin_strobe_n, pin_autofd_n, pin_selin_n, pin_init_n, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pport_regfile dut (.*);

    // {wdata, {selin_n, init_n, autofd_n, strobe_n}, oe}
    localparam logic [12:0] VEC [8] = '{
        {8'h00, 4'b1011, 1'b1},
        {8'h01, 4'b1010, 1'b1},
        {8'h02, 4'b1001, 1'b1},
        {8'h04, 4'b1111, 1'b1},
        {8'h08, 4'b0011, 1'b1},
        {8'h20, 4'b1011, 1'b0},
        {8'h2F, 4'b0100, 1'b0},
        {8'hC0, 4'b1011, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        rst = 1'b1; host_addr = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
        pin_data_in = 8'h00; pin_busy = 0; pin_ack_n = 0; pin_perror = 0;
        pin_select = 0; pin_fault_n = 0;
        ticks(3);
        rst = 1'b0;
        ticks(1);

        // R1 reset state
        check("R1 pins", {pin_selin_n, pin_init_n, pin_autofd_n, pin_strobe_n}, 4'b1011);
        check("R1 oe", pin_data_oe, 1);
        check("R1 data", pin_data_out, 0);
        check("R1 irq", irq, 0);

        // R6 R3 R7 control vectors
        for (int i = 0; i < 8; i++) begin
            wr(2'd2, VEC[i][12:5]);
            check("R6 pins", {pin_selin_n, pin_init_n, pin_autofd_n, pin_strobe_n}, VEC[i][4:1]);
            check("R3 oe", pin_data_oe, VEC[i][0]);
            rd(2'd2, r);
            check("R7 readback", r, VEC[i][12:5] & 8'h3F);
        end
        rd(2'd3, r);
        check("R7 addr3", r, 0);

        // R2 data write and R3 value held while released
        wr(2'd0, 8'hA5);
        check("R2 data out", pin_data_out, 8'hA5);
        wr(2'd2, 8'h20);
        check("R3 released", pin_data_oe, 0);
        check("R3 value held", pin_data_out, 8'hA5);
        wr(2'd2, 8'h00);

        // R4 data read returns pins, R11 two-edge latency
        @(negedge clk); pin_data_in = 8'h3C;
        @(negedge clk); host_addr = 2'd0; #1;
        check("R11 one edge", host_rdata, 8'h00);
        @(negedge clk); #1;
        check("R4 pins read", host_rdata, 8'h3C);

        // R5 status mapping
        pin_busy = 1; pin_ack_n = 0; pin_perror = 1; pin_select = 0; pin_fault_n = 1;
        ticks(3);
        rd(2'd1, r);
        check("R5 status a", r, 8'b0010_1000);
        pin_busy = 0; pin_ack_n = 1; pin_perror = 0; pin_select = 1; pin_fault_n = 0;
        ticks(3);
        rd(2'd1, r);
        check("R5 status b", r, 8'b1101_0000);

        // R8 write to status ignored
        wr(2'd2, 8'h05);
        wr(2'd1, 8'hFF);
        check("R8 data", pin_data_out, 8'hA5);
        check("R8 ctrl pins", {pin_selin_n, pin_init_n, pin_autofd_n, pin_strobe_n}, 4'b1110);
        rd(2'd2, r);
        check("R8 ctrl reg", r, 8'h05);

        // R9 edges while disabled and falling edges do nothing
        pin_ack_n = 0; ticks(4);
        pin_ack_n = 1; ticks(4);
        check("R9 disabled", irq, 0);
        wr(2'd2, 8'h10);
        pin_ack_n = 0; ticks(4);
        check("R9 falling", irq, 0);
        // rising edge with enable: flag after third edge
        @(negedge clk); pin_ack_n = 1;
        @(negedge clk); @(negedge clk);
        check("R9 not yet", irq, 0);
        @(negedge clk);
        check("R9 set", irq, 1);
        ticks(5);
        check("R10 sticky", irq, 1);

        // R10 collision: clear and new edge in the same cycle
        pin_ack_n = 0; ticks(4);
        @(negedge clk); pin_ack_n = 1;
        @(negedge clk); @(negedge clk);
        host_addr = 2'd1; host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
        check("R10 edge wins", irq, 1);
        rd(2'd1, r);
        check("R10 cleared", irq, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule